// File: doc/BRIEF.md
# Claimable DMA Channel Controller

This block is a single DMA channel driven through a small word-addressed register window. Before software may start a copy it has to take ownership of the channel by setting a claim flag. Taking ownership also clears the staged transfer parameters (byte count, source, destination and configuration) to known defaults. The run flag is only accepted from a control write that arrives while the channel is already owned.

When a run is accepted, the staged values are copied into read-only execution registers and the engine moves data through a byte-wide memory master port. It works in transactions whose length is a power of two chosen by the configuration. Each transaction is fully read into an internal chunk buffer and then written out. A tail shorter than one transaction goes out as a final short chunk. At the end the engine can optionally reload its execution registers from the staged values. It then marks the control register done and drops run. The channel state (idle, started, done) is also driven on an output pin.

Top module: `cdma_channel`

## Requirements
- R1: After reset the control register reads 0, the staged config reads 0x066, the staged and exec counts and addresses read 0, and `chan_state` is 0 (encoding: 0 idle, 1 started, 2 done).
- R2: Register word offsets: 0 control (bit0 claim, bit1 run, bit2 done), 1 config (bits[3:0] read exponent, bits[7:4] write exponent, bit8 repeat), 2 staged count, 3 staged destination, 4 staged source, 5 exec count, 6 exec destination, 7 exec source. Writes to offsets 5, 6 and 7 have no effect.
- R3: A control write that sets claim while the channel is unclaimed resets the staged count, destination and source to 0 and the staged config to 0x066. A claim write on an already claimed channel leaves the staged values alone.
- R4: A control write on an unclaimed channel stores claim and done as written, stores run as 0, and starts no transfer.
- R5: A control write with run set on a claimed channel that is not busy copies the staged values into the exec registers and moves `chan_state` to 1 on the following cycle.
- R6: The transaction length is 1 << min(read exponent, write exponent, 6) bytes.
- R7: Data moves in chunks. Every chunk except the last is one full transaction. All reads of a chunk are issued, at ascending addresses, before any of its writes.
- R8: When the count is not a multiple of the transaction length, the leftover bytes form one final short chunk. The whole count is copied, and no byte past destination+count is written.
- R9: A run with a staged count of 0 reaches the done state without any memory access.
- R10: On completion `chan_state` becomes 2, control run clears and done sets. Without repeat, the exec count reads 0 and the exec addresses have each advanced by the count.
- R11: With the repeat bit set, the exec count, source and destination read back the staged values after completion.
- R12: While `chan_state` is 1, all register writes (control and staged) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rd_req | output | 1 | Memory byte read request, one cycle per byte |
| rd_addr | output | AW | Memory read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 8 | Read data byte |
| wr_req | output | 1 | Memory byte write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 8 | Memory write data byte |
| chan_state | output | 2 | 0 idle, 1 started, 2 done |

## Verification
The assertions assume that the memory returns exactly one response per read request and never returns one without a pending request. The bench's memory model always answers on the cycle after the request. The bench sweeps exponent pairs, including pairs that exceed the cap, across byte counts that are exact multiples, short tails and counts larger than one transaction. For every run it computes the expected chunk sizes, the final exec values and the copied bytes arithmetically. Register writes made during a transfer are issued only while the channel reports started, so the ignore rule is exercised without racing completion.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_BUSY = 2'd1,
        CH_DONE = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic done;
        logic run;
        logic claim;
    } ctrl_t;

    typedef struct packed {
        logic       repeat_en;
        logic [3:0] wr_exp;
        logic [3:0] rd_exp;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_CHK  = 2'd0,
        PH_RD   = 2'd1,
        PH_RWT  = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_CFG    = 3'd1;
    localparam logic [2:0] OFS_NBYTES = 3'd2;
    localparam logic [2:0] OFS_NDST   = 3'd3;
    localparam logic [2:0] OFS_NSRC   = 3'd4;
    localparam logic [2:0] OFS_XBYTES = 3'd5;
    localparam logic [2:0] OFS_XDST   = 3'd6;
    localparam logic [2:0] OFS_XSRC   = 3'd7;

    localparam cfg_t CFG_DEFAULT = '{repeat_en: 1'b0, wr_exp: 4'd6, rd_exp: 4'd6};

    function automatic logic [3:0] xfer_exp(cfg_t c, logic [3:0] cap);
        logic [3:0] m;
        m = (c.rd_exp < c.wr_exp) ? c.rd_exp : c.wr_exp;
        return (m > cap) ? cap : m;
    endfunction

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          busy,
    input  logic          fin,
    output ctrl_t         ctrl_q,
    output cfg_t          cfg_q,
    output logic [CW-1:0] nbytes_q,
    output logic [AW-1:0] ndst_q,
    output logic [AW-1:0] nsrc_q,
    output logic          start
);

    logic  wr_ctrl;
    logic  claim_edge;
    ctrl_t ctrl_in;

    assign wr_ctrl    = reg_we && (reg_addr == OFS_CTRL) && !busy;
    assign claim_edge = wr_ctrl && !ctrl_q.claim && reg_wdata[0];
    assign start      = wr_ctrl && ctrl_q.claim && reg_wdata[1];

    always_comb begin
        ctrl_in = ctrl_t'(reg_wdata[2:0]);
        if (!ctrl_q.claim) ctrl_in.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (fin) begin
            ctrl_q.run  <= 1'b0;
            ctrl_q.done <= 1'b1;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || claim_edge) begin
            cfg_q    <= CFG_DEFAULT;
            nbytes_q <= '0;
            ndst_q   <= '0;
            nsrc_q   <= '0;
        end else if (reg_we && !busy) begin
            case (reg_addr)
                OFS_CFG:    cfg_q    <= cfg_t'(reg_wdata[8:0]);
                OFS_NBYTES: nbytes_q <= reg_wdata[CW-1:0];
                OFS_NDST:   ndst_q   <= reg_wdata[AW-1:0];
                OFS_NSRC:   nsrc_q   <= reg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    a_r4_unclaimed_no_run: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CTRL && !busy && !ctrl_q.claim) |=> !ctrl_q.run);

    a_r3_claim_resets_staged: assert property (@(posedge clk) disable iff (rst)
        claim_edge |=> (nbytes_q == '0 && ndst_q == '0 && nsrc_q == '0 && cfg_q == CFG_DEFAULT));

    a_r12_staged_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(nbytes_q) && $stable(nsrc_q) && $stable(ndst_q) && $stable(cfg_q)));

endmodule

// File: rtl/cdma_chunk_buf.sv
module cdma_chunk_buf #(
    parameter int DEPTH = 64,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign rdata = store[ridx];

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int MAX_EXP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  cfg_t          cfg,
    input  logic [CW-1:0] nbytes,
    input  logic [AW-1:0] ndst,
    input  logic [AW-1:0] nsrc,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_resp_valid,
    input  logic [7:0]    rd_resp_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          fin,
    output chan_state_e   state,
    output logic [CW-1:0] xbytes,
    output logic [AW-1:0] xdst,
    output logic [AW-1:0] xsrc
);

    localparam int BUF_D = 1 << MAX_EXP;
    localparam int LW    = MAX_EXP + 1;
    localparam int BIW   = (BUF_D > 1) ? $clog2(BUF_D) : 1;

    phase_e        phase;
    logic [LW-1:0] idx;
    logic [LW-1:0] chunk_q;
    logic [LW-1:0] chunk_n;
    logic [CW-1:0] tbytes;
    logic [3:0]    texp;
    logic          last_idx;
    logic          buf_we;

    assign texp     = xfer_exp(cfg, 4'(MAX_EXP));
    assign tbytes   = CW'(1) << texp;
    assign chunk_n  = (xbytes < tbytes) ? LW'(xbytes) : LW'(tbytes);
    assign last_idx = (idx == LW'(chunk_q - 1'b1));
    assign buf_we   = (state == CH_BUSY) && (phase == PH_RWT) && rd_resp_valid;

    assign fin      = (state == CH_BUSY) && (phase == PH_CHK) && (xbytes == '0);
    assign rd_req   = (state == CH_BUSY) && (phase == PH_RD);
    assign wr_req   = (state == CH_BUSY) && (phase == PH_WR);
    assign rd_addr  = xsrc + AW'(idx);
    assign wr_addr  = xdst + AW'(idx);

    cdma_chunk_buf #(.DEPTH(BUF_D)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (idx[BIW-1:0]),
        .wdata (rd_resp_data),
        .ridx  (idx[BIW-1:0]),
        .rdata (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CH_IDLE;
            phase   <= PH_CHK;
            idx     <= '0;
            chunk_q <= '0;
            xbytes  <= '0;
            xdst    <= '0;
            xsrc    <= '0;
        end else if (start) begin
            state  <= CH_BUSY;
            phase  <= PH_CHK;
            idx    <= '0;
            xbytes <= nbytes;
            xdst   <= ndst;
            xsrc   <= nsrc;
        end else if (state == CH_BUSY) begin
            case (phase)
                PH_CHK: begin
                    if (xbytes == '0) begin
                        state <= CH_DONE;
                        if (cfg.repeat_en) begin
                            xbytes <= nbytes;
                            xdst   <= ndst;
                            xsrc   <= nsrc;
                        end
                    end else begin
                        chunk_q <= chunk_n;
                        idx     <= '0;
                        phase   <= PH_RD;
                    end
                end
                PH_RD: phase <= PH_RWT;
                PH_RWT: begin
                    if (rd_resp_valid) begin
                        if (last_idx) begin
                            idx   <= '0;
                            phase <= PH_WR;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= PH_RD;
                        end
                    end
                end
                PH_WR: begin
                    if (last_idx) begin
                        xsrc   <= xsrc + AW'(chunk_q);
                        xdst   <= xdst + AW'(chunk_q);
                        xbytes <= xbytes - CW'(chunk_q);
                        idx    <= '0;
                        phase  <= PH_CHK;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= PH_CHK;
            endcase
        end
    end

    a_r10_count_never_grows: assert property (@(posedge clk) disable iff (rst)
        (state == CH_BUSY && $past(state) == CH_BUSY) |-> (xbytes <= $past(xbytes)));

    a_r6_chunk_in_range: assert property (@(posedge clk) disable iff (rst)
        (state == CH_BUSY && phase != PH_CHK) |-> (chunk_q != '0 && CW'(chunk_q) <= tbytes));

    a_r7_write_inside_chunk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> ((wr_addr - xdst) < AW'(chunk_q)));

    a_r9_zero_count_finishes: assert property (@(posedge clk) disable iff (rst)
        (start && nbytes == '0) |=> (fin && !rd_req && !wr_req));

    a_r7_no_stray_response: assert property (@(posedge clk) disable iff (rst)
        rd_resp_valid |-> $past(rd_req));

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
    import cdma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int MAX_EXP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_resp_valid,
    input  logic [7:0]    rd_resp_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [1:0]    chan_state
);

    ctrl_t         ctrl_q;
    cfg_t          cfg_q;
    logic [CW-1:0] nbytes_q;
    logic [AW-1:0] ndst_q;
    logic [AW-1:0] nsrc_q;
    logic [CW-1:0] xbytes;
    logic [AW-1:0] xdst;
    logic [AW-1:0] xsrc;
    logic          start;
    logic          fin;
    logic          busy;
    chan_state_e   state;

    assign busy       = (state == CH_BUSY);
    assign chan_state = state;

    cdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .fin       (fin),
        .ctrl_q    (ctrl_q),
        .cfg_q     (cfg_q),
        .nbytes_q  (nbytes_q),
        .ndst_q    (ndst_q),
        .nsrc_q    (nsrc_q),
        .start     (start)
    );

    cdma_engine #(.AW(AW), .CW(CW), .MAX_EXP(MAX_EXP)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .cfg           (cfg_q),
        .nbytes        (nbytes_q),
        .ndst          (ndst_q),
        .nsrc          (nsrc_q),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data),
        .wr_req        (wr_req),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .fin           (fin),
        .state         (state),
        .xbytes        (xbytes),
        .xdst          (xdst),
        .xsrc          (xsrc)
    );

    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = 32'(ctrl_q);
            OFS_CFG:    reg_rdata = 32'(cfg_q);
            OFS_NBYTES: reg_rdata = 32'(nbytes_q);
            OFS_NDST:   reg_rdata = 32'(ndst_q);
            OFS_NSRC:   reg_rdata = 32'(nsrc_q);
            OFS_XBYTES: reg_rdata = 32'(xbytes);
            OFS_XDST:   reg_rdata = 32'(xdst);
            default:    reg_rdata = 32'(xsrc);
        endcase
    end

    a_r10_fin_marks_done: assert property (@(posedge clk) disable iff (rst)
        fin |=> (ctrl_q.done && !ctrl_q.run && state == CH_DONE));

    a_r5_start_goes_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == CH_BUSY && ctrl_q.run));

    a_r7_one_access_per_cycle: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

endmodule

// File: tb/tb_cdma_channel.sv
module tb_cdma_channel;

    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          rd_resp_valid = 1'b0;
    logic [7:0]    rd_resp_data = '0;
    logic [7:0]    wr_data;
    logic [1:0]    chan_state;

    always #5 clk = ~clk;

    cdma_channel #(.AW(AW), .CW(CW), .MAX_EXP(6)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .chan_state(chan_state)
    );

    // memory model and access recorder
    logic [7:0] mem [1024];
    int rd_cnt = 0, wr_cnt = 0, nchunks = 0, streak = 0, wr_oob = 0;
    int burst_len [4096];
    int lo_bound = 0, hi_bound = 0;

    always @(posedge clk) begin
        rd_resp_valid <= rd_req;
        if (rd_req) begin
            rd_resp_data <= mem[rd_addr[9:0]];
            rd_cnt <= rd_cnt + 1;
            streak <= streak + 1;
        end
        if (wr_req) begin
            mem[wr_addr[9:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
            if (int'(wr_addr) < lo_bound || int'(wr_addr) >= hi_bound) wr_oob <= wr_oob + 1;
            if (streak != 0) begin
                burst_len[nchunks] <= streak;
                nchunks <= nchunks + 1;
                streak <= 0;
            end
        end
    end

    int n_checks = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (chan_state == 2'd2) begin ok = 1'b1; break; end
        end
    endtask

    task automatic expect_reg(input logic [2:0] a, input int exp, input string req);
        int v;
        rreg(a, v);
        check(v == exp, req, v, exp);
    endtask

    // runs one transfer on a claimed channel and checks everything about it
    task automatic run_copy(input int rde, input int wre, input int n, input int src,
                            input int dst, input bit rep, input int seed);
        int t, e, r0, w0, c0, oob0, bad, nch, v;
        bit ok;
        e = (rde < wre) ? rde : wre;
        if (e > 6) e = 6;
        t = 1 << e;
        for (int i = 0; i < n; i++) mem[src + i] = 8'((i * 7 + seed) & 255);
        for (int i = 0; i <= n; i++) mem[dst + i] = 8'hEE;
        lo_bound = dst; hi_bound = dst + n;
        wreg(3'd1, (int'(rep) << 8) | (wre << 4) | rde);
        wreg(3'd2, n);
        wreg(3'd3, dst);
        wreg(3'd4, src);
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt; c0 = nchunks; oob0 = wr_oob;
        wreg(3'd0, 3);
        wait_done(ok);
        check(ok, "R10 reached done", int'(chan_state), 2);
        @(negedge clk);
        @(negedge clk);
        expect_reg(3'd0, 5, "R10 control claim+done, run clear");
        bad = 0;
        for (int i = 0; i < n; i++)
            if (mem[dst + i] != 8'((i * 7 + seed) & 255)) bad++;
        check(bad == 0, "R8 bytes copied", bad, 0);
        check(mem[dst + n] == 8'hEE, "R8 no write past end", int'(mem[dst + n]), 238);
        check(wr_oob == oob0, "R8 writes inside destination", wr_oob - oob0, 0);
        check(rd_cnt - r0 == n && wr_cnt - w0 == n, "R7 one read and one write per byte",
              rd_cnt - r0, n);
        nch = (n + t - 1) / t;
        check(nchunks - c0 == nch, "R6 chunk count", nchunks - c0, nch);
        bad = 0;
        for (int i = 0; i < nch && i < nchunks - c0; i++) begin
            v = n - i * t;
            if (v > t) v = t;
            if (burst_len[c0 + i] != v) bad++;
        end
        check(bad == 0, "R7 reads of each chunk precede its writes, chunk lengths", bad, 0);
        if (rep) begin
            expect_reg(3'd5, n, "R11 exec count reloaded");
            expect_reg(3'd6, dst, "R11 exec dst reloaded");
            expect_reg(3'd7, src, "R11 exec src reloaded");
        end else begin
            expect_reg(3'd5, 0, "R10 exec count zero");
            expect_reg(3'd6, dst + n, "R10 exec dst advanced");
            expect_reg(3'd7, src + n, "R10 exec src advanced");
        end
    endtask

    initial begin : main
        int v, r0;
        bit ok;
        int sizes [8] = '{1, 2, 5, 8, 13, 64, 65, 70};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(3'd0, 0, "R1 control");
        expect_reg(3'd1, 32'h66, "R1 config");
        expect_reg(3'd2, 0, "R1 staged count");
        expect_reg(3'd7, 0, "R1 exec src");
        check(chan_state == 2'd0, "R1 idle", int'(chan_state), 0);

        // R2 exec registers are read-only
        wreg(3'd5, 99);
        wreg(3'd7, 123);
        expect_reg(3'd5, 0, "R2 exec count unwritable");
        expect_reg(3'd7, 0, "R2 exec src unwritable");

        // R4 unclaimed run ignored
        wreg(3'd2, 9);
        wreg(3'd4, 5);
        expect_reg(3'd2, 9, "R2 staged count writable");
        r0 = rd_cnt;
        wreg(3'd0, 2);
        repeat (4) @(negedge clk);
        expect_reg(3'd0, 0, "R4 run forced clear");
        check(chan_state == 2'd0, "R4 no transfer", int'(chan_state), 0);

        // R3 and R4: claim with run together
        wreg(3'd0, 3);
        repeat (4) @(negedge clk);
        expect_reg(3'd0, 1, "R4 claim stored, run dropped");
        check(chan_state == 2'd0 && rd_cnt == r0, "R4 still idle", int'(chan_state), 0);
        expect_reg(3'd2, 0, "R3 staged count reset");
        expect_reg(3'd4, 0, "R3 staged src reset");
        expect_reg(3'd1, 32'h66, "R3 staged config reset");

        // R3 second claim does not reset
        wreg(3'd2, 7);
        wreg(3'd0, 1);
        expect_reg(3'd2, 7, "R3 claim on claimed channel keeps staged");

        // R9 zero count
        wreg(3'd2, 0);
        r0 = rd_cnt;
        wreg(3'd0, 3);
        wait_done(ok);
        check(ok, "R9 done reached", int'(chan_state), 2);
        check(rd_cnt == r0, "R9 no memory reads", rd_cnt - r0, 0);
        expect_reg(3'd0, 5, "R9 control done");

        // R5 start and R12 writes ignored while busy
        for (int i = 0; i < 40; i++) mem[256 + i] = 8'(i + 100);
        lo_bound = 512; hi_bound = 552;
        wreg(3'd1, 32'h00);
        wreg(3'd2, 40);
        wreg(3'd3, 512);
        wreg(3'd4, 256);
        wreg(3'd0, 3);
        check(chan_state == 2'd1, "R5 started", int'(chan_state), 1);
        expect_reg(3'd5, 40, "R5 exec count loaded");
        wreg(3'd2, 3);
        wreg(3'd4, 0);
        wreg(3'd0, 0);
        check(chan_state == 2'd1, "R12 control write ignored while busy", int'(chan_state), 1);
        wait_done(ok);
        check(ok, "R12 transfer completed", int'(chan_state), 2);
        expect_reg(3'd2, 40, "R12 staged count kept");
        expect_reg(3'd4, 256, "R12 staged src kept");
        expect_reg(3'd0, 5, "R12 control kept claim");
        check(mem[512 + 39] == 8'(139), "R12 full copy", int'(mem[551]), 139);

        // R6 R7 R8 R10 sweep over exponent pairs and counts
        for (int k = 0; k <= 8; k++)
            for (int s = 0; s < 8; s++)
                run_copy(k, 15 - k, sizes[s], 256, 512, 1'b0, k * 8 + s);

        // R11 repeat
        run_copy(2, 3, 10, 256, 768, 1'b1, 3);
        run_copy(9, 9, 70, 300, 600, 1'b1, 11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        wait (cyc >= 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule